// File: doc/BRIEF.md
# Register-Mapped Power-Bus Command Issuer

This block is a small debug controller on a memory-mapped register port. Software uses it to run one transaction at a time on a serial power-management bus. Software first loads up to eight write-data byte registers. It then sets the target fields: slave, peripheral, register offset and length. Finally it writes an opcode to the launch register.

The launch write clears the status register and raises a one-cycle request toward a downstream bus engine. The request carries every command field and all the write bytes. When the engine answers, the block records completion with a done flag and three error qualifiers. For a clean read it also stores the returned bytes in eight read-data registers, which software then fetches.

A fuse input can disable the controller. While the fuse is asserted, a launch is refused at once and nothing goes downstream. Only one transaction may be outstanding at a time.

Top module: `dbg_cmd_issuer`

## Requirements
- R1: After reset every mapped register reads zero, no request is raised and the block is idle.
- R2: A write to 0x04 stores the slave ID from bits [3:0] and the length-minus-one from bits [6:4]. A write to 0x08 stores the peripheral ID from bits [7:0], and a write to 0x0C stores the register offset from bits [7:0]. Each reads back in the same bit positions, and each drives its request field. Offset 0x00 reads back the opcode of the last launched transaction in bits [5:1].
- R3: A write to 0x00 while idle, with the fuse clear, takes the opcode from bits [5:1] and clears the status register. It asserts `req_valid` for exactly one cycle, in the cycle after the write.
- R4: Write byte i (0..7) is held in bits [7:0] of the register at 0x18+4i and is presented on `req_wbytes[8i+7:8i]`.
- R5: A response accepted while a transaction is outstanding sets status bit 0 (done). In the same update it copies failure into bit 1, denied into bit 2 and dropped into bit 3, and the block returns to idle.
- R6: The read-type opcodes are 1, 8, 13 and 15. After such a response with all three error flags clear, byte i of `rsp_rbytes` reads from bits [7:0] at 0x38+4i. For any other opcode, or when an error flag is set, the read-data registers keep their previous contents.
- R7: While a transaction is outstanding, status reads zero. A further write to 0x00 starts no request, leaves status unchanged and leaves the stored opcode unchanged.
- R8: With the fuse input high, a launch write while idle raises no request and sets status to 0x5 (done and denied).
- R9: Reads of unmapped offsets (0x10, 0x58 and above, and any address with bits [1:0] non-zero) return zero. Writes to those offsets, to status or to the read-data registers change nothing.
- R10: A response arriving while the block is idle changes neither status nor the read-data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fuse_off | input | 1 | Controller disabled when high |
| reg_addr | input | AW | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational from address) |
| req_valid | output | 1 | One-cycle transaction request |
| req_opcode | output | 5 | Bus opcode |
| req_sid | output | 4 | Slave ID |
| req_pid | output | 8 | Peripheral ID |
| req_offset | output | 8 | Register offset in peripheral |
| req_len_m1 | output | 3 | Byte count minus one |
| req_wbytes | output | 8*NBYTES | Write bytes, byte i in lane i |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_fail | input | 1 | Response failure flag |
| rsp_denied | input | 1 | Response denied flag |
| rsp_dropped | input | 1 | Response dropped flag |
| rsp_rbytes | input | 8*NBYTES | Returned read bytes |

## Verification
The bench uses the default parameters: AW=8, DW=32, NBYTES=8. With these values the full write-data window (0x18 to 0x34) and read-data window (0x38 to 0x54) can be reached, together with the unmapped hole at 0x10 and the space past 0x54. The random transactions cover every legal opcode, both read and write types, every error-flag combination and engine delays of varying length. The directed cases cover launches while busy, the fused state and responses that arrive while idle.

// File: rtl/dbg_cmd_pkg.sv
`timescale 1ns/1ps
package dbg_cmd_pkg;
    localparam logic [7:0] OFS_LAUNCH = 8'h00;
    localparam logic [7:0] OFS_TARGET = 8'h04;
    localparam logic [7:0] OFS_PERIPH = 8'h08;
    localparam logic [7:0] OFS_REGOFS = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_WBASE  = 8'h18;
    localparam logic [7:0] OFS_RBASE  = 8'h38;

    localparam int unsigned OP_W  = 5;
    localparam int unsigned SID_W = 4;
    localparam int unsigned LEN_W = 3;
    localparam int unsigned ST_W  = 4;

    // status bit positions
    localparam int unsigned ST_DONE = 0;
    localparam int unsigned ST_FAIL = 1;
    localparam int unsigned ST_DENY = 2;
    localparam int unsigned ST_DROP = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_XWR_LONG = 5'd1 - 5'd1,
        OPC_XRD_LONG = 5'd1,
        OPC_XWR      = 5'd2,
        OPC_BUS_RST  = 5'd3,
        OPC_SLEEP    = 5'd4,
        OPC_SHUTDN   = 5'd5,
        OPC_WAKE     = 5'd6,
        OPC_AUTH     = 5'd7,
        OPC_MRD      = 5'd8,
        OPC_MWR      = 5'd9,
        OPC_XRD      = 5'd13,
        OPC_WR       = 5'd14,
        OPC_RD       = 5'd15,
        OPC_ZWR      = 5'd16
    } bus_op_e;

    function automatic logic op_is_read(input logic [OP_W-1:0] op);
        return (op == OPC_XRD_LONG) || (op == OPC_MRD) ||
               (op == OPC_XRD)      || (op == OPC_RD);
    endfunction
endpackage

// File: rtl/dbg_addr_decode.sv
`timescale 1ns/1ps
module dbg_addr_decode
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned NBYTES = 8,
    localparam int unsigned IDX_W = $clog2(NBYTES),
    localparam int unsigned SPAN  = 4 * NBYTES
) (
    input  logic [AW-1:0]    addr,
    output logic             hit_launch,
    output logic             hit_target,
    output logic             hit_periph,
    output logic             hit_regofs,
    output logic             hit_status,
    output logic             hit_wd,
    output logic             hit_rd,
    output logic [IDX_W-1:0] wd_idx,
    output logic [IDX_W-1:0] rd_idx
);
    logic [AW-1:0] wrel;
    logic [AW-1:0] rrel;
    logic          aligned;

    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        wrel       = addr - AW'(OFS_WBASE);
        rrel       = addr - AW'(OFS_RBASE);
        hit_launch = (addr == AW'(OFS_LAUNCH));
        hit_target = (addr == AW'(OFS_TARGET));
        hit_periph = (addr == AW'(OFS_PERIPH));
        hit_regofs = (addr == AW'(OFS_REGOFS));
        hit_status = (addr == AW'(OFS_STATUS));
        hit_wd     = aligned && (addr >= AW'(OFS_WBASE)) && (wrel < AW'(SPAN));
        hit_rd     = aligned && (addr >= AW'(OFS_RBASE)) && (rrel < AW'(SPAN));
        wd_idx     = wrel[IDX_W+1:2];
        rd_idx     = rrel[IDX_W+1:2];
    end

    logic unused_rel;
    assign unused_rel = ^{wrel, rrel};
endmodule

// File: rtl/dbg_byte_bank.sv
`timescale 1ns/1ps
module dbg_byte_bank #(
    parameter int unsigned NBYTES = 8,
    localparam int unsigned IDX_W = $clog2(NBYTES),
    localparam int unsigned BW    = 8 * NBYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic             cap_en,
    input  logic [BW-1:0]    cap_bytes,
    output logic [BW-1:0]    wbytes,
    output logic [BW-1:0]    rbytes
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        typedef struct packed {
            logic [7:0] wb;
            logic [7:0] rb;
        } lane_t;
        lane_t lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (wr_en && (wr_idx == IDX_W'(g))) lane_d.wb = wr_byte;
            if (cap_en)                         lane_d.rb = cap_bytes[8*g +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign wbytes[8*g +: 8] = lane_q.wb;
        assign rbytes[8*g +: 8] = lane_q.rb;
    end
endmodule

// File: rtl/dbg_txn_ctrl.sv
`timescale 1ns/1ps
module dbg_txn_ctrl
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_off,
    input  logic             we,
    input  logic [DW-1:0]    wdata,
    input  logic             hit_launch,
    input  logic             hit_target,
    input  logic             hit_periph,
    input  logic             hit_regofs,
    input  logic             rsp_valid,
    input  logic             rsp_fail,
    input  logic             rsp_denied,
    input  logic             rsp_dropped,
    output logic             busy,
    output logic             req_valid,
    output logic [OP_W-1:0]  op,
    output logic [SID_W-1:0] sid,
    output logic [LEN_W-1:0] len_m1,
    output logic [7:0]       pid,
    output logic [7:0]       regofs,
    output logic [ST_W-1:0]  status,
    output logic             cap_en
);
    typedef struct packed {
        logic             busy;
        logic             req;
        logic [OP_W-1:0]  op;
        logic [SID_W-1:0] sid;
        logic [LEN_W-1:0] len;
        logic [7:0]       pid;
        logic [7:0]       ofs;
        logic [ST_W-1:0]  st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic launch_wr;
    logic rsp_take;

    always_comb begin
        launch_wr = we && hit_launch;
        rsp_take  = ctl_q.busy && rsp_valid;
        cap_en    = rsp_take && op_is_read(ctl_q.op) &&
                    !(rsp_fail || rsp_denied || rsp_dropped);

        ctl_d     = ctl_q;
        ctl_d.req = 1'b0;

        if (rsp_take) begin
            ctl_d.busy           = 1'b0;
            ctl_d.st[ST_DONE]    = 1'b1;
            ctl_d.st[ST_FAIL]    = rsp_fail;
            ctl_d.st[ST_DENY]    = rsp_denied;
            ctl_d.st[ST_DROP]    = rsp_dropped;
        end
        if (we && hit_target) begin
            ctl_d.sid = wdata[SID_W-1:0];
            ctl_d.len = wdata[SID_W +: LEN_W];
        end
        if (we && hit_periph) ctl_d.pid = wdata[7:0];
        if (we && hit_regofs) ctl_d.ofs = wdata[7:0];

        if (launch_wr && !ctl_q.busy) begin
            if (fuse_off) begin
                ctl_d.st          = '0;
                ctl_d.st[ST_DONE] = 1'b1;
                ctl_d.st[ST_DENY] = 1'b1;
            end else begin
                ctl_d.busy = 1'b1;
                ctl_d.req  = 1'b1;
                ctl_d.op   = wdata[1 +: OP_W];
                ctl_d.st   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy      = ctl_q.busy;
    assign req_valid = ctl_q.req;
    assign op        = ctl_q.op;
    assign sid       = ctl_q.sid;
    assign len_m1    = ctl_q.len;
    assign pid       = ctl_q.pid;
    assign regofs    = ctl_q.ofs;
    assign status    = ctl_q.st;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DW-1:8];

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R3
    AST_REQ_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_launch && !busy && !fuse_off) |=> (req_valid && status == '0)); // R3
    AST_FUSE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_launch && !busy && fuse_off) |=> (!req_valid && status == 4'h5)); // R8
    AST_BUSY_IGNORES_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_launch && busy && !rsp_valid) |=> (!req_valid && $stable(status) && $stable(op))); // R7
    AST_BUSY_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status == '0)); // R7
    AST_RSP_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_valid) |=> (status[ST_DONE] && !busy)); // R5
    AST_IDLE_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rsp_valid && !we) |=> $stable(status)); // R10
endmodule

// File: rtl/dbg_cmd_issuer.sv
`timescale 1ns/1ps
module dbg_cmd_issuer
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned NBYTES = 8,
    localparam int unsigned IDX_W = $clog2(NBYTES),
    localparam int unsigned BW    = 8 * NBYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_off,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_we,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             req_valid,
    output logic [4:0]       req_opcode,
    output logic [3:0]       req_sid,
    output logic [7:0]       req_pid,
    output logic [7:0]       req_offset,
    output logic [2:0]       req_len_m1,
    output logic [BW-1:0]    req_wbytes,
    input  logic             rsp_valid,
    input  logic             rsp_fail,
    input  logic             rsp_denied,
    input  logic             rsp_dropped,
    input  logic [BW-1:0]    rsp_rbytes
);
    logic             hit_launch, hit_target, hit_periph, hit_regofs;
    logic             hit_status, hit_wd, hit_rd;
    logic [IDX_W-1:0] wd_idx, rd_idx;
    logic             busy, cap_en;
    logic [ST_W-1:0]  status;
    logic [BW-1:0]    rbytes;

    dbg_addr_decode #(.AW(AW), .NBYTES(NBYTES)) u_dec (
        .addr       (reg_addr),
        .hit_launch (hit_launch),
        .hit_target (hit_target),
        .hit_periph (hit_periph),
        .hit_regofs (hit_regofs),
        .hit_status (hit_status),
        .hit_wd     (hit_wd),
        .hit_rd     (hit_rd),
        .wd_idx     (wd_idx),
        .rd_idx     (rd_idx)
    );

    dbg_txn_ctrl #(.DW(DW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fuse_off    (fuse_off),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .hit_launch  (hit_launch),
        .hit_target  (hit_target),
        .hit_periph  (hit_periph),
        .hit_regofs  (hit_regofs),
        .rsp_valid   (rsp_valid),
        .rsp_fail    (rsp_fail),
        .rsp_denied  (rsp_denied),
        .rsp_dropped (rsp_dropped),
        .busy        (busy),
        .req_valid   (req_valid),
        .op          (req_opcode),
        .sid         (req_sid),
        .len_m1      (req_len_m1),
        .pid         (req_pid),
        .regofs      (req_offset),
        .status      (status),
        .cap_en      (cap_en)
    );

    dbg_byte_bank #(.NBYTES(NBYTES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we && hit_wd),
        .wr_idx    (wd_idx),
        .wr_byte   (reg_wdata[7:0]),
        .cap_en    (cap_en),
        .cap_bytes (rsp_rbytes),
        .wbytes    (req_wbytes),
        .rbytes    (rbytes)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            hit_launch: reg_rdata = DW'({req_opcode, 1'b0});
            hit_target: reg_rdata = DW'({req_len_m1, req_sid});
            hit_periph: reg_rdata = DW'(req_pid);
            hit_regofs: reg_rdata = DW'(req_offset);
            hit_status: reg_rdata = DW'(status);
            hit_wd:     reg_rdata = DW'(req_wbytes[8*wd_idx +: 8]);
            hit_rd:     reg_rdata = DW'(rbytes[8*rd_idx +: 8]);
            default:    reg_rdata = '0;
        endcase
    end

    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: tb/tb_dbg_cmd_issuer.sv
`timescale 1ns/1ps
module tb_dbg_cmd_issuer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fuse_off = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [4:0]  req_opcode;
    logic [3:0]  req_sid;
    logic [7:0]  req_pid, req_offset;
    logic [2:0]  req_len_m1;
    logic [63:0] req_wbytes;
    logic        rsp_valid = 1'b0, rsp_fail = 1'b0, rsp_denied = 1'b0, rsp_dropped = 1'b0;
    logic [63:0] rsp_rbytes = '0;

    dbg_cmd_issuer dut (.*);

    always #2.5 clk = ~clk;

    int nvec = 0, nerr = 0;
    bit done_flag = 0;
    logic [7:0] exp_wb[8];
    logic [7:0] exp_rb[8];
    logic [3:0] exp_st;
    logic [4:0] exp_op;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic is_rd(input logic [4:0] op);
        return op == 5'd1 || op == 5'd8 || op == 5'd13 || op == 5'd15;
    endfunction

    function automatic logic [4:0] pick_op(input int k);
        case (k % 14)
            0: return 5'd0;  1: return 5'd1;  2: return 5'd2;  3: return 5'd3;
            4: return 5'd4;  5: return 5'd5;  6: return 5'd6;  7: return 5'd7;
            8: return 5'd8;  9: return 5'd9;  10: return 5'd13; 11: return 5'd14;
            12: return 5'd15; default: return 5'd16;
        endcase
    endfunction

    function automatic logic [63:0] pack_wb();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = exp_wb[i];
        return v;
    endfunction

    task automatic check_rdata(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(8'h38 + 8'(4*i), d);
            chk(tag, d, {24'h0, exp_rb[i]});
        end
    endtask

    task automatic txn(input logic [4:0] op, input logic [2:0] fl, input int dly, input bit busy_try);
        logic [3:0]  sid = 4'($urandom);
        logic [2:0]  len = 3'($urandom);
        logic [7:0]  pid = 8'($urandom);
        logic [7:0]  ofs = 8'($urandom);
        logic [63:0] rb  = {$urandom, $urandom};
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            if ($urandom % 2 == 0) begin
                exp_wb[i] = 8'($urandom);
                wr(8'h18 + 8'(4*i), {24'hABCDEF, exp_wb[i]});
            end
        end
        wr(8'h0C, {24'hFFFFFF, ofs});
        wr(8'h08, {24'h123456, pid});
        wr(8'h04, {25'h1, len, sid});
        rd(8'h04, d); chk("R2 target readback", d, {25'h0, len, sid});
        wr(8'h00, {26'h0, op, 1'b0});
        exp_op = op; exp_st = 4'h0;
        chk("R3 req pulse", req_valid, 1);
        chk("R3 opcode", req_opcode, op);
        chk("R2 req fields", {req_sid, req_len_m1, req_pid, req_offset}, {sid, len, pid, ofs});
        chk("R4 write bytes", req_wbytes, pack_wb());
        @(negedge clk);
        chk("R3 pulse width", req_valid, 0);
        rd(8'h14, d); chk("R3 status cleared", d, 0);
        if (busy_try) begin
            wr(8'h00, {26'h0, 5'd14 ^ op, 1'b0});
            chk("R7 no second req", req_valid, 0);
            rd(8'h14, d); chk("R7 status busy", d, 0);
            rd(8'h00, d); chk("R7 opcode kept", d, {26'h0, op, 1'b0});
        end
        repeat (dly) @(negedge clk);
        rsp_valid = 1; rsp_fail = fl[0]; rsp_denied = fl[1]; rsp_dropped = fl[2];
        rsp_rbytes = rb;
        @(negedge clk);
        rsp_valid = 0; rsp_fail = 0; rsp_denied = 0; rsp_dropped = 0;
        exp_st = {fl[2], fl[1], fl[0], 1'b1};
        if (is_rd(op) && fl == 3'b000)
            for (int i = 0; i < 8; i++) exp_rb[i] = rb[8*i +: 8];
        rd(8'h14, d); chk("R5 status", d, {28'h0, exp_st});
        check_rdata("R6 read data");
        rd(8'h00, d); chk("R2 launch readback", d, {26'h0, exp_op, 1'b0});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            nerr++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) begin exp_wb[i] = 0; exp_rb[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req idle", req_valid, 0);
        foreach (exp_wb[i]) begin
            rd(8'h18 + 8'(4*i), d); chk("R1 wdata zero", d, 0);
        end
        rd(8'h00, d); chk("R1 launch zero", d, 0);
        rd(8'h04, d); chk("R1 target zero", d, 0);
        rd(8'h08, d); chk("R1 periph zero", d, 0);
        rd(8'h0C, d); chk("R1 regofs zero", d, 0);
        rd(8'h14, d); chk("R1 status zero", d, 0);
        check_rdata("R1 rdata zero");

        // directed: clean read, error read, write, busy launch
        txn(5'd15, 3'b000, 0, 0);
        txn(5'd13, 3'b010, 3, 1);
        txn(5'd14, 3'b000, 1, 1);
        txn(5'd8,  3'b100, 2, 0);
        txn(5'd1,  3'b000, 5, 1);

        // R8: fuse blocks launch
        fuse_off = 1'b1;
        wr(8'h00, {26'h0, 5'd15, 1'b0});
        chk("R8 no req fused", req_valid, 0);
        @(negedge clk);
        chk("R8 no req fused later", req_valid, 0);
        rd(8'h14, d); chk("R8 status deny", d, 32'h5);
        fuse_off = 1'b0;

        // R10: response while idle
        @(negedge clk);
        rsp_valid = 1; rsp_fail = 1; rsp_dropped = 1; rsp_rbytes = 64'hDEAD_BEEF_0BAD_F00D;
        @(negedge clk);
        rsp_valid = 0; rsp_fail = 0; rsp_dropped = 0;
        rd(8'h14, d); chk("R10 status unchanged", d, 32'h5);
        check_rdata("R10 rdata unchanged");

        // R9: unmapped and read-only
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R9 hole reads zero", d, 0);
        rd(8'h58, d); chk("R9 past end zero", d, 0);
        rd(8'hFC, d); chk("R9 top zero", d, 0);
        rd(8'h1A, d); chk("R9 misaligned zero", d, 0);
        wr(8'h19, 32'h77);
        rd(8'h18, d); chk("R9 misaligned write", d, {24'h0, exp_wb[0]});
        wr(8'h14, 32'hF);
        rd(8'h14, d); chk("R9 status read-only", d, 32'h5);
        wr(8'h3C, 32'h5A);
        check_rdata("R9 rdata read-only");

        // random transactions
        for (int n = 0; n < 60; n++) begin
            logic [2:0] fl = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            txn(pick_op(int'($urandom % 14)), fl, int'($urandom % 6), bit'($urandom % 4 == 0));
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule